// File: doc/BRIEF.md
# Scanline Counter Interrupt from a Pattern-Address Line

This block counts video scanlines by watching a single address line of the graphics memory bus. That line goes high whenever a pattern fetch targets the upper pattern table. It raises an interrupt once a programmable number of lines have passed. The line is sampled once per CPU clock.

A rise is taken as a scanline tick only after the line has stayed low for a minimum number of CPU cycles. A burst of fetches a few dots apart therefore counts once, and rises further apart each count. Each tick either reloads a down-counter from a period value or decrements it. Software sets the period, forces a reload, and enables or disables the interrupt through a small write-only register port. Disabling the interrupt also acknowledges it.

A static configuration pin selects between two behaviours. They differ only in what happens when the counter meets zero, which matters most for a period of 0. Control and status pins are plain levels. Nothing streams through the block, so it has no valid/ready handshake.

Top module: `line_irq_top`

## Requirements
- R1: A tick is taken when `a12_in` is 1 in a cycle and was 0 in each of at least LOW_MIN (default 3) immediately preceding cycles. A rise after fewer low cycles is ignored. The low-cycle count clears whenever `a12_in` is 1.
- R2: Rises separated by single low cycles (a burst of pattern fetches) give exactly one tick per burst. Rises separated by LOW_MIN or more low cycles each give a tick.
- R3: If `a12_in` never rises, no tick occurs and `irq_n` stays 1 whatever the period.
- R4: On a tick, the counter loads the period if it is 0 or a reload is pending, and otherwise decrements by 1. A pending reload is cleared by that tick.
- R5: With `zero_mode`=0, a tick that leaves the counter at 0 sets the flag when the interrupt is enabled. A period of 0 therefore flags on every tick.
- R6: With `zero_mode`=1, only a tick that decrements the counter from 1 to 0 sets the flag. A period of 0 never flags.
- R7: A write (`wr_en`=1) uses `wr_sel` as follows: 0 stores `wr_data` as the period, 1 requests a reload, 2 disables the interrupt, and 3 enables it.
- R8: A disable write clears a set flag, so `irq_n` is 1 on the next cycle. No tick sets the flag while the interrupt is disabled, and a later enable does not set it retroactively.
- R9: `irq_n` is the inverted flag. It goes low in the cycle after the clock edge that samples the qualifying rise, and it stays low until a disable write.
- R10: After reset, `irq_n` is 1, the interrupt is disabled, the counter and period are 0, and the low-cycle count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a12_in | input | 1 | Sampled pattern-table address line |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (R7 encoding) |
| wr_data | input | 8 | Write data (period value) |
| zero_mode | input | 1 | 0 = normal zero behaviour, 1 = alternate |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: LOW_MIN of 3 and an 8-bit counter. With a threshold of 3, a 113-cycle scanline model can place burst rises one low cycle apart and spaced rises four low cycles apart. It can also hit the exact 2-versus-3 low-cycle boundary. The 8-bit width leaves room for periods of 0, 1, 3 and 5 in both zero behaviours, so the reload, decrement and zero paths are all reached within a few lines.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD  = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_IRQ_OFF = 2'd2,
    SEL_IRQ_ON  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/a12_rise_filter.sv
module a12_rise_filter #(
  parameter int LOW_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a12_in,
  output logic tick
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam logic [LW-1:0] SAT = LW'(LOW_MIN);

  logic [LW-1:0] low_cnt;

  // count low cycles, saturating; any high cycle clears
  always_ff @(posedge clk) begin
    if (!rst_n)             low_cnt <= '0;
    else if (a12_in)        low_cnt <= '0;
    else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end

  assign tick = a12_in && (low_cnt == SAT);

  // R1: a tick is always a fresh rise
  a_r1_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !$past(a12_in));
  // R2: two adjacent cycles never both tick
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/line_down_counter.sv
module line_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         zero_mode,
  input  logic         wr_period,
  input  logic         wr_reload,
  input  logic [W-1:0] wr_data,
  output logic         zero_hit
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt, period, nxt;
  logic         req, load;

  always_comb begin
    load = (cnt == '0) || req;
    nxt  = load ? period : (cnt - ONE);
    if (zero_mode) zero_hit = tick && !load && (cnt == ONE);
    else           zero_hit = tick && (nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      period <= '0;
      req    <= 1'b0;
    end else begin
      if (tick)      cnt    <= nxt;
      if (wr_period) period <= wr_data;
      req <= wr_reload | (req & ~tick);
    end
  end

  // R4: plain decrement when neither zero nor reload pending
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !req) |=> cnt == $past(cnt) - ONE);
  // R4: pending reload loads the period
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && req) |=> cnt == $past(period));
  // R4: counter moves only on a tick
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R6: alternate hits leave the counter at zero
  a_r6_alt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_hit && zero_mode) |=> cnt == '0);
endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_hit,
  input  logic wr_off,
  input  logic wr_on,
  output logic flag
);
  logic en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (wr_off)     en <= 1'b0;
      else if (wr_on) en <= 1'b1;
      if (wr_off)                flag <= 1'b0;
      else if (zero_hit && en)   flag <= 1'b1;
    end
  end

  // R8: disable write acknowledges
  a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> !flag);
  // R8: no new flag while disabled
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(flag));
  // R9: flag holds until a disable write
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_off) |=> flag);
endmodule

// File: rtl/line_irq_top.sv
module line_irq_top
  import line_irq_pkg::*;
#(
  parameter int LOW_MIN = 3,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a12_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             zero_mode,
  output logic             irq_n
);
  logic tick, zero_hit, flag;
  logic wr_period, wr_reload, wr_off, wr_on;
  reg_sel_e sel;

  assign sel       = reg_sel_e'(wr_sel);
  assign wr_period = wr_en && (sel == SEL_PERIOD);
  assign wr_reload = wr_en && (sel == SEL_RELOAD);
  assign wr_off    = wr_en && (sel == SEL_IRQ_OFF);
  assign wr_on     = wr_en && (sel == SEL_IRQ_ON);

  a12_rise_filter #(.LOW_MIN(LOW_MIN)) u_filt (
    .clk(clk), .rst_n(rst_n), .a12_in(a12_in), .tick(tick));

  line_down_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .zero_mode(zero_mode),
    .wr_period(wr_period), .wr_reload(wr_reload), .wr_data(wr_data),
    .zero_hit(zero_hit));

  irq_flag_ctl u_flag (
    .clk(clk), .rst_n(rst_n), .zero_hit(zero_hit),
    .wr_off(wr_off), .wr_on(wr_on), .flag(flag));

  assign irq_n = ~flag;

  // R3: no line activity, no new request
  a_r3_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !a12_in |=> !$fell(irq_n));
endmodule

// File: tb/line_irq_top_test.sv
module line_irq_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a12 = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       zmode = 1'b0;
  logic       irq_n;

  int n_chk = 0;
  int n_fail = 0;

  localparam int LINE_CYC = 113;
  // {pattern[1:0] (0 none,1 burst,2 spaced), mode, period[7:0], lines[3:0], first_irq_line[3:0] (0 = never)}
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {2'd1, 1'b0, 8'd3, 4'd6, 4'd4},
    {2'd1, 1'b1, 8'd3, 4'd6, 4'd4},
    {2'd1, 1'b0, 8'd0, 4'd3, 4'd1},
    {2'd1, 1'b1, 8'd0, 4'd4, 4'd0},
    {2'd0, 1'b0, 8'd0, 4'd4, 4'd0},
    {2'd2, 1'b0, 8'd5, 4'd3, 4'd2},
    {2'd2, 1'b1, 8'd1, 4'd2, 4'd1},
    {2'd1, 1'b0, 8'd1, 4'd3, 4'd2}
  };

  line_irq_top uut (
    .clk(clk), .rst_n(rst_n), .a12_in(a12), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .zero_mode(zmode), .irq_n(irq_n));

  always #2 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_n=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drv(input logic v);
    @(negedge clk);
    a12 = v;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [7:0] per, input logic m);
    zmode = m;
    wr(2'd2, 8'd0);
    wr(2'd0, per);
    wr(2'd1, 8'd0);
    wr(2'd3, 8'd0);
  endtask

  task automatic line(input logic [1:0] pat);
    int used = 0;
    if (pat == 2'd1) begin
      for (int i = 0; i < 8; i++) begin drv(1'b1); drv(1'b0); end
      used = 16;
    end else if (pat == 2'd2) begin
      for (int i = 0; i < 4; i++) begin
        drv(1'b1);
        for (int k = 0; k < 4; k++) drv(1'b0);
      end
      used = 20;
    end
    for (int i = used; i < LINE_CYC; i++) drv(1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: irq_n=%0b expected finish", irq_n);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_n, 1'b1, "R10 reset");

    // table walk: R2 R3 R5 R6 R7 R4
    for (int v = 0; v < NV; v++) begin
      logic [1:0] pat;
      logic       m;
      logic [7:0] per;
      logic [3:0] nl, fe;
      {pat, m, per, nl, fe} = VEC[v];
      setup(per, m);
      for (int l = 1; l <= int'(nl); l++) begin
        line(pat);
        chk(irq_n, (fe != 0 && l >= int'(fe)) ? 1'b0 : 1'b1,
            pat == 0 ? "R3 idle" : (m ? "R6 alt" : "R5 normal / R2 count"));
      end
    end

    // R9: exact cycle of assertion
    setup(8'd0, 1'b0);
    for (int i = 0; i < 4; i++) drv(1'b0);
    drv(1'b1);
    chk(irq_n, 1'b1, "R9 before edge");
    drv(1'b0);
    chk(irq_n, 1'b0, "R9 after edge");

    // R1: two low cycles is too few, three is enough
    setup(8'd1, 1'b0);
    for (int i = 0; i < 4; i++) drv(1'b0);
    drv(1'b1);
    drv(1'b0); drv(1'b0);
    drv(1'b1);
    drv(1'b0);
    chk(irq_n, 1'b1, "R1 short low ignored");
    drv(1'b0); drv(1'b0);
    drv(1'b1);
    drv(1'b0);
    chk(irq_n, 1'b0, "R1 full low counted");

    // R8: disable acknowledges and silences
    wr(2'd2, 8'd0);
    chk(irq_n, 1'b1, "R8 off clears");
    for (int l = 0; l < 3; l++) begin
      line(2'd1);
      chk(irq_n, 1'b1, "R8 disabled quiet");
    end
    wr(2'd3, 8'd0);
    drv(1'b0);
    chk(irq_n, 1'b1, "R8 enable not retroactive");

    // R9: flag persists without acknowledge
    line(2'd1); line(2'd1);
    chk(irq_n, 1'b0, "R9 set");
    for (int i = 0; i < 50; i++) drv(1'b0);
    chk(irq_n, 1'b0, "R9 held");

    // R4: reload request restarts the countdown
    setup(8'd3, 1'b0);
    line(2'd1); line(2'd1);
    wr(2'd1, 8'd0);
    line(2'd1); line(2'd1);
    chk(irq_n, 1'b1, "R4 reload restarted");
    line(2'd1);
    chk(irq_n, 1'b1, "R4 one left");
    line(2'd1);
    chk(irq_n, 1'b0, "R4 zero after reload");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule